// File: doc/BRIEF.md
# Receive PCM bus frame-sync timebase

This block tracks where a receive PCM system bus currently stands. It keeps a bit counter, a time-slot counter and a frame counter, all clocked by the bus clock, and raises a bit strobe for the data path on the last clock of every bit period. A double-rate setting makes the bus clock run at twice the bit rate, so each bit period then spans two clocks.

The block runs in one of two modes. As bus master it drives a shared sync pin and asserts that pin's output enable. The pin pulses once per frame or once per multiframe, at a programmed slot and bit offset from the frame boundary. The pulse can be launched from either clock edge. As slave it releases the pin and watches it as an input. The first clock on which the pin reads high is taken as the first clock of the offset bit, and the counters jump to match. If the counters are already in step, that reload changes nothing.

Top module: `pcm_sync_timebase`

## Requirements
- R1: While `rst_n` is low, `bit_cnt`, `slot_cnt` and `frame_cnt` read 0. Counting starts from position 0 at the first rising clock edge after release.
- R2: `sync_oe` equals `cfg_master`. In slave mode (`cfg_master`=0), `sync_out` stays 0 at every position, including the sync position.
- R3: `bit_cnt` counts 0..BITS-1 and advances on each clock where `bit_stb` is high. `slot_cnt` advances when `bit_cnt` wraps and counts 0..SLOTS-1. `frame_cnt` advances when `slot_cnt` wraps and counts 0..FRAMES-1.
- R4: With `cfg_dbl`=0, `bit_stb` is high on every clock. With `cfg_dbl`=1, `bit_stb` is low on the first clock after reset and then alternates, and the counters hold on clocks where it is low.
- R5: In master mode with `cfg_mf_sel`=0 and `cfg_fall`=0, `sync_out` is high exactly while `slot_cnt`=`cfg_ts_off` and `bit_cnt`=`cfg_bit_off`, in every frame.
- R6: In master mode with `cfg_mf_sel`=1, `sync_out` is high only at that slot/bit position when `frame_cnt`=0, so it pulses once per multiframe.
- R7: With `cfg_fall`=1, `sync_out` changes on the falling clock edge and follows the rising-edge version half a clock later.
- R8: In slave mode, the first clock on which `sync_in` reads high after a low is treated as the first clock of bit (`cfg_ts_off`, `cfg_bit_off`). In single rate, the counters then show the following bit. In double rate, they show that bit with `bit_stb` high. A `sync_in` that stays high does not reload again.
- R9: A slave sync pulse that arrives when the counters are already aligned leaves the count sequence unchanged.
- R10: On a slave reload, `frame_cnt` becomes 0 when `cfg_mf_sel`=1 and keeps its running value when `cfg_mf_sel`=0.
- R11: In master mode, `sync_in` has no effect on the counters.
- R12: A sync pulse lasts one bit period, which is 1 clock in single rate and 2 clocks in double rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = drive sync (master), 0 = follow sync (slave) |
| cfg_mf_sel | input | 1 | 1 = multiframe sync, 0 = frame sync |
| cfg_dbl | input | 1 | 1 = two clocks per bit |
| cfg_fall | input | 1 | 1 = launch sync_out on the falling edge |
| cfg_ts_off | input | $clog2(SLOTS) | Sync time-slot offset |
| cfg_bit_off | input | $clog2(BITS) | Sync bit offset |
| sync_in | input | 1 | Sync pin as input (slave) |
| sync_out | output | 1 | Sync pin as output (master) |
| sync_oe | output | 1 | Sync pin output enable |
| bit_stb | output | 1 | Last clock of the current bit period |
| bit_cnt | output | $clog2(BITS) | Current bit number |
| slot_cnt | output | $clog2(SLOTS) | Current time slot |
| frame_cnt | output | $clog2(FRAMES) | Current frame in the multiframe |

## Verification
The bench uses the default parameters: 32 slots, 8 bits and 16 frames. A single multiframe therefore takes 4096 clocks in single rate and 8192 in double rate. That is short enough to walk a full multiframe for each table entry, which covers every frame wrap, the last-slot/last-bit offset and the rare multiframe pulse. The directed part covers slave reloads, both misaligned and aligned, in both rate modes, along with the falling-edge launch and a master that ignores its input.

// File: rtl/pcm_sync_timebase.sv
module pcm_sync_timebase #(
  parameter int SLOTS  = 32,
  parameter int BITS   = 8,
  parameter int FRAMES = 16,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS),
  localparam int FW = $clog2(FRAMES),
  localparam int PW = FW + SW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic          cfg_mf_sel,
  input  logic          cfg_dbl,
  input  logic          cfg_fall,
  input  logic [SW-1:0] cfg_ts_off,
  input  logic [BW-1:0] cfg_bit_off,
  input  logic          sync_in,
  output logic          sync_out,
  output logic          sync_oe,
  output logic          bit_stb,
  output logic [BW-1:0] bit_cnt,
  output logic [SW-1:0] slot_cnt,
  output logic [FW-1:0] frame_cnt
);

  logic [BW-1:0] bit_q;
  logic [SW-1:0] slot_q;
  logic [FW-1:0] frm_q;
  logic          ph_q, sync_d, fall_q;

  function automatic logic [PW-1:0] step(input logic [FW-1:0] f,
                                         input logic [SW-1:0] s,
                                         input logic [BW-1:0] b);
    logic [FW-1:0] nf;
    logic [SW-1:0] ns;
    logic [BW-1:0] nb;
    nf = f;
    ns = s;
    nb = b + 1'b1;
    if (b == BW'(BITS - 1)) begin
      nb = '0;
      ns = s + 1'b1;
      if (s == SW'(SLOTS - 1)) begin
        ns = '0;
        nf = (f == FW'(FRAMES - 1)) ? '0 : f + 1'b1;
      end
    end
    return {nf, ns, nb};
  endfunction

  wire           stb   = !cfg_dbl || ph_q;
  wire           rise  = !cfg_master && sync_in && !sync_d;
  wire           match = (bit_q == cfg_bit_off) && (slot_q == cfg_ts_off) &&
                         (!cfg_mf_sel || frm_q == '0);
  wire [FW-1:0]  fbase = cfg_mf_sel ? '0 : frm_q;
  wire [PW-1:0]  run_nxt  = step(frm_q, slot_q, bit_q);
  wire [PW-1:0]  load_nxt = cfg_dbl ? {fbase, cfg_ts_off, cfg_bit_off}
                                    : step(fbase, cfg_ts_off, cfg_bit_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      slot_q <= '0;
      frm_q  <= '0;
      ph_q   <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync_d <= sync_in;
      if (rise) begin
        {frm_q, slot_q, bit_q} <= load_nxt;
        ph_q <= cfg_dbl;
      end else begin
        ph_q <= cfg_dbl && !ph_q;
        if (stb) {frm_q, slot_q, bit_q} <= run_nxt;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= match;
  end

  assign sync_out  = cfg_master && (cfg_fall ? fall_q : match);
  assign sync_oe   = cfg_master;
  assign bit_stb   = stb;
  assign bit_cnt   = bit_q;
  assign slot_cnt  = slot_q;
  assign frame_cnt = frm_q;

  a_r2_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!sync_out && !sync_oe));

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bit_q) < BITS) && (int'(slot_q) < SLOTS) && (int'(frm_q) < FRAMES));

  a_r3_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && stb && int'(bit_q) == BITS - 1) |=> (bit_q == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !stb) |=> ($stable(bit_q) && $stable(slot_q) && $stable(frm_q)));

  a_r4_dbl_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_dbl && stb) |=> (!stb || !cfg_dbl));

  a_r11_master_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !cfg_dbl) |=> (bit_q == $past(bit_q) + 1'b1 || bit_q == '0));

endmodule

// File: tb/sim_pcm_sync_timebase.sv
`timescale 1ns/1ps
module sim_pcm_sync_timebase;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_mf_sel = 1'b0, cfg_dbl = 1'b0, cfg_fall = 1'b0;
  logic [4:0] cfg_ts_off = '0;
  logic [2:0] cfg_bit_off = '0;
  logic sync_in = 1'b0;
  logic sync_out, sync_oe, bit_stb;
  logic [2:0] bit_cnt;
  logic [4:0] slot_cnt;
  logic [3:0] frame_cnt;
  int total = 0, bad = 0;

  pcm_sync_timebase u0 (.clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .cfg_mf_sel(cfg_mf_sel), .cfg_dbl(cfg_dbl), .cfg_fall(cfg_fall),
    .cfg_ts_off(cfg_ts_off), .cfg_bit_off(cfg_bit_off), .sync_in(sync_in),
    .sync_out(sync_out), .sync_oe(sync_oe), .bit_stb(bit_stb),
    .bit_cnt(bit_cnt), .slot_cnt(slot_cnt), .frame_cnt(frame_cnt));

  always #2 clk = ~clk;

  // {mf_sel, dbl, ts_off[4:0], bit_off[2:0]}
  localparam logic [9:0] VEC [4] = '{
    {1'b0, 1'b0, 5'd0,  3'd0},
    {1'b0, 1'b1, 5'd17, 3'd5},
    {1'b1, 1'b0, 5'd31, 3'd7},
    {1'b1, 1'b1, 5'd9,  3'd2}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic mf, input logic d, input logic f,
                          input int ts, input int bo);
    sync_in = 1'b0;
    rst_n = 1'b0;
    tick();
    cfg_master = m; cfg_mf_sel = mf; cfg_dbl = d; cfg_fall = f;
    cfg_ts_off = 5'(ts); cfg_bit_off = 3'(bo);
    tick();
    chk("R1 bit in reset", int'(bit_cnt), 0);
    chk("R1 slot in reset", int'(slot_cnt), 0);
    chk("R1 frame in reset", int'(frame_cnt), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mb, ms, mfr, mph, len, w, syncs, cnt_err, sync_err, stb_err;
    logic vmf, vd;
    int vts, vbo, fr;
    // Table walk: master, rising edge, one full multiframe per entry (R3 R4 R5 R6 R12)
    foreach (VEC[i]) begin
      vmf = VEC[i][9]; vd = VEC[i][8]; vts = int'(VEC[i][7:3]); vbo = int'(VEC[i][2:0]);
      do_reset(1'b1, vmf, vd, 1'b0, vts, vbo);
      chk("R2 master oe", int'(sync_oe), 1);
      w = vd ? 2 : 1;
      len = 4096 * w;
      mb = 0; ms = 0; mfr = 0; mph = 0;
      syncs = 0; cnt_err = 0; sync_err = 0; stb_err = 0;
      for (int n = 0; n < len; n++) begin
        if (int'(bit_cnt) != mb || int'(slot_cnt) != ms || int'(frame_cnt) != mfr) cnt_err++;
        if (bit_stb != (!vd || mph != 0)) stb_err++;
        if (sync_out != (mb == vbo && ms == vts && (!vmf || mfr == 0))) sync_err++;
        if (sync_out) syncs++;
        tick();
        if (!vd || mph != 0) begin
          mb++;
          if (mb == 8) begin
            mb = 0; ms++;
            if (ms == 32) begin ms = 0; mfr = (mfr + 1) % 16; end
          end
        end
        mph = vd ? (mph == 0 ? 1 : 0) : 0;
      end
      chk("R3 counter mismatches", cnt_err, 0);
      chk("R4 strobe mismatches", stb_err, 0);
      chk(vmf ? "R6 sync mismatches" : "R5 sync mismatches", sync_err, 0);
      chk("R12 sync clocks per multiframe", syncs, vmf ? w : 16 * w);
    end

    // R7: falling-edge launch, offset slot 0 bit 2
    do_reset(1'b1, 1'b0, 1'b0, 1'b1, 0, 2);
    tick(); tick();
    chk("R7 not yet at rise", int'(sync_out), 0);
    #2;
    chk("R7 high after fall", int'(sync_out), 1);
    tick();
    chk("R7 held past next rise", int'(sync_out), 1);
    #2;
    chk("R7 low after next fall", int'(sync_out), 0);

    // R11: master ignores sync_in
    do_reset(1'b1, 1'b0, 1'b0, 1'b0, 5, 3);
    repeat (100) tick();
    sync_in = 1'b1;
    tick();
    chk("R11 slot unchanged", int'(slot_cnt), 12);
    chk("R11 bit unchanged", int'(bit_cnt), 5);
    sync_in = 1'b0;

    // R8/R9/R10/R2: slave, single rate, offset slot 5 bit 3
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 5, 3);
    chk("R2 slave oe", int'(sync_oe), 0);
    repeat (100) tick();
    sync_in = 1'b1;
    tick();
    chk("R8 load slot", int'(slot_cnt), 5);
    chk("R8 load bit", int'(bit_cnt), 4);
    chk("R10 frame kept", int'(frame_cnt), 0);
    tick();
    chk("R8 held high no reload", int'(bit_cnt), 5);
    sync_in = 1'b0;
    for (int k = 0; k < 300 && !(slot_cnt == 5 && bit_cnt == 3); k++) tick();
    chk("R2 slave quiet at sync spot", int'(sync_out), 0);
    fr = int'(frame_cnt);
    chk("R9 reached spot in next frame", fr, 1);
    sync_in = 1'b1;
    tick();
    chk("R9 aligned slot", int'(slot_cnt), 5);
    chk("R9 aligned bit", int'(bit_cnt), 4);
    chk("R9 aligned frame", int'(frame_cnt), fr);
    sync_in = 1'b0;
    cfg_mf_sel = 1'b1;
    repeat (3) tick();
    sync_in = 1'b1;
    tick();
    chk("R10 multiframe reload frame", int'(frame_cnt), 0);
    chk("R10 multiframe reload bit", int'(bit_cnt), 4);
    sync_in = 1'b0;

    // R8: slave, double rate, offset slot 2 bit 6
    do_reset(1'b0, 1'b0, 1'b1, 1'b0, 2, 6);
    repeat (37) tick();
    sync_in = 1'b1;
    tick();
    chk("R8 dbl slot", int'(slot_cnt), 2);
    chk("R8 dbl bit", int'(bit_cnt), 6);
    chk("R8 dbl strobe", int'(bit_stb), 1);
    tick();
    chk("R8 dbl next bit", int'(bit_cnt), 7);
    chk("R8 dbl next strobe", int'(bit_stb), 0);
    sync_in = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule